// File: doc/BRIEF.md
# Speculatively Indexed L1 Tag Controller with Synonym Relocation

This block is the tag side of a direct-mapped first-level data cache. It picks the set from the virtual address and compares against a physical tag. With 64-byte lines, 128 sets and a 4 KB page, six of the seven index bits lie inside the page offset and need no translation. The seventh, address bit 12, is taken from the virtual address as a guess. The controller reads the entry while the translation is in flight. When the physical page number returns, the controller compares the stored 20-bit physical tag (physical bits 31..12, which include bit 12) against it, so a hit also confirms the guessed bit.

On a miss the controller asks the next level for the line. The next level either reports a plain fill, or reports that the cache already holds the line in the set whose bit 12 is flipped. A plain fill is recorded in the set that was looked up. A flipped-index report starts a relocation. The controller names the current occupant of the correct set, physical bit 12, as the victim and requests a move. On completion it writes the tag into the correct set and invalidates the source set. A translation fault ends the access with an error code and changes nothing. A flush request clears every entry in a walk of one set per cycle, and new requests wait until the walk finishes.

The controller is built around one state machine. Its states are IDLE, XLAT (waiting for translation), MISS_REQ / MISS_WAIT (fetch request and response), MOVE_REQ / MOVE_WAIT (relocation request and response), RESP (holding the answer) and FLUSH. The transitions are as follows:
- IDLE goes to FLUSH when a flush is pending, and otherwise to XLAT when a request is accepted.
- XLAT goes to RESP on a fault or a hit, and to MISS_REQ on a miss.
- MISS_REQ goes to MISS_WAIT when the request is taken.
- MISS_WAIT goes to RESP on a fill, and to MOVE_REQ on a flipped-index report.
- MOVE_REQ goes to MOVE_WAIT when the request is taken.
- MOVE_WAIT goes to RESP on the response.
- RESP goes to IDLE when the requester takes the answer.
- FLUSH goes to IDLE after the last set.

Top module: `vipt_l1_ctrl`

## Requirements
- R1: After reset every entry is invalid and `cpu_req_ready` is high, so the first access to any line misses.
- R2: A request is accepted only in IDLE with no flush pending. In the accepting cycle `xlat_req_valid` is high with `xlat_req_vpn` equal to virtual address bits 31..12. `cpu_req_ready` stays low until the access has been answered.
- R3: An access hits only when the set selected by virtual bits 12..6 is valid and its stored tag equals the returned 20-bit physical page number. A hit answers with code 0 (HIT) and makes no next-level request.
- R4: On a miss the controller raises `nl_req_valid` with `nl_req_op` = 0 (FETCH) and `nl_req_paddr` = {page number, virtual bits 11..6, six zero bits}. Both stay stable until `nl_req_ready`.
- R5: A next-level response with `nl_rsp_alias` = 0 writes the physical tag, valid, into the set that was looked up (virtual bits 12..6) and answers code 1 (FILL).
- R6: A response with `nl_rsp_alias` = 1 triggers a request with `nl_req_op` = 1 (MOVE) and the same line address. The victim fields carry the valid bit and tag of the set {physical bit 12, virtual bits 11..6}. Its response writes the tag into that set, invalidates the set with bit 12 flipped, and answers code 2 (MOVED).
- R7: A translation fault answers code 3 (FAULT), issues no next-level request and leaves every entry unchanged.
- R8: `cpu_rsp_valid` and `cpu_rsp_code` hold steady until `cpu_rsp_ready`.
- R9: A flush taken in IDLE keeps `cpu_req_ready` low for 128 cycles. Afterwards every entry is invalid.
- R10: A flush pulse seen while an access is in progress is remembered and starts the walk right after that access is answered. `cpu_req_ready` then stays low for 129 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Pulse to invalidate all entries |
| cpu_req_valid | input | 1 | Requester presents an address |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_vaddr | input | 32 | Virtual byte address |
| cpu_rsp_valid | output | 1 | Answer available |
| cpu_rsp_ready | input | 1 | Requester takes the answer |
| cpu_rsp_code | output | 2 | 0 HIT, 1 FILL, 2 MOVED, 3 FAULT |
| xlat_req_valid | output | 1 | Translation start, one cycle |
| xlat_req_vpn | output | 20 | Virtual page number |
| xlat_rsp_valid | input | 1 | Translation result present |
| xlat_rsp_ppn | input | 20 | Physical page number |
| xlat_rsp_fault | input | 1 | Translation failed |
| nl_req_valid | output | 1 | Next-level request |
| nl_req_ready | input | 1 | Next level takes the request |
| nl_req_op | output | 1 | 0 FETCH, 1 MOVE |
| nl_req_paddr | output | 32 | Physical line address |
| nl_req_victim_valid | output | 1 | Target set holds a line to evict |
| nl_req_victim_tag | output | 20 | Tag of that victim |
| nl_rsp_valid | input | 1 | Next-level response |
| nl_rsp_ready | output | 1 | Controller accepts the response |
| nl_rsp_alias | input | 1 | Line held at the flipped-bit set |

## Verification
Some properties are checked on every cycle. A stalled next-level request keeps its address and opcode, and an untaken answer keeps its code. No request is accepted while an answer or next-level transfer is outstanding. A fault is answered as FAULT in the next cycle. Every invalidate or tag write leaves the addressed entry in the expected state. Other behaviour is shown only by the bench's scenarios, which run accesses against its own model of the tag array. These are: which set a fill lands in, and that relocation empties the source set (seen through later hits and misses). They also cover the victim reported for a move, the state left untouched after a fault, and the exact stall length of an immediate and of a deferred flush.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLAT,
        ST_MISS_REQ,
        ST_MISS_WAIT,
        ST_MOVE_REQ,
        ST_MOVE_WAIT,
        ST_RESP,
        ST_FLUSH
    } ctrl_state_e;

    localparam logic [1:0] RSP_HIT   = 2'd0;
    localparam logic [1:0] RSP_FILL  = 2'd1;
    localparam logic [1:0] RSP_MOVED = 2'd2;
    localparam logic [1:0] RSP_FAULT = 2'd3;

    localparam logic NL_FETCH = 1'b0;
    localparam logic NL_MOVE  = 1'b1;

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int SETS_LOG2 = 7,
    parameter int TAG_W     = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SETS_LOG2-1:0] rd_idx,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    input  logic [SETS_LOG2-1:0] vic_idx,
    output logic                 vic_valid,
    output logic [TAG_W-1:0]     vic_tag,
    input  logic                 wr_en,
    input  logic [SETS_LOG2-1:0] wr_idx,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic                 inv_en,
    input  logic [SETS_LOG2-1:0] inv_idx
);
    localparam int NSETS = 1 << SETS_LOG2;

    logic [NSETS-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [NSETS];

    // valid bits: invalidate is applied after write so it wins on a clash
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (wr_en)  valid_q[wr_idx]  <= 1'b1;
            if (inv_en) valid_q[inv_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign vic_valid = valid_q[vic_idx];
    assign vic_tag   = tag_q[vic_idx];

    // R9
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !valid_q[$past(inv_idx)]);

    // R5
    write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(inv_en && inv_idx == wr_idx))
            |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/vipt_tag_cmp.sv
module vipt_tag_cmp #(
    parameter int TAG_W = 20
) (
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [TAG_W-1:0] xl_tag,
    input  logic             xl_fault,
    output logic             hit,
    output logic             need_fetch
);
    logic tag_eq;

    assign tag_eq     = (ent_tag == xl_tag);
    assign hit        = ent_valid && tag_eq && !xl_fault;
    assign need_fetch = !xl_fault && !(ent_valid && tag_eq);

endmodule

// File: rtl/vipt_l1_ctrl.sv
module vipt_l1_ctrl
    import vipt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_W    = 6,
    parameter int PAGE_W    = 12,
    parameter int SETS_LOG2 = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     cpu_req_valid,
    output logic                     cpu_req_ready,
    input  logic [ADDR_W-1:0]        cpu_req_vaddr,
    output logic                     cpu_rsp_valid,
    input  logic                     cpu_rsp_ready,
    output logic [1:0]               cpu_rsp_code,
    output logic                     xlat_req_valid,
    output logic [ADDR_W-PAGE_W-1:0] xlat_req_vpn,
    input  logic                     xlat_rsp_valid,
    input  logic [ADDR_W-PAGE_W-1:0] xlat_rsp_ppn,
    input  logic                     xlat_rsp_fault,
    output logic                     nl_req_valid,
    input  logic                     nl_req_ready,
    output logic                     nl_req_op,
    output logic [ADDR_W-1:0]        nl_req_paddr,
    output logic                     nl_req_victim_valid,
    output logic [ADDR_W-PAGE_W-1:0] nl_req_victim_tag,
    input  logic                     nl_rsp_valid,
    output logic                     nl_rsp_ready,
    input  logic                     nl_rsp_alias
);
    localparam int TAG_W    = ADDR_W - PAGE_W;
    localparam int INPAGE_W = PAGE_W - LINE_W;
    localparam int NSPEC    = SETS_LOG2 - INPAGE_W;
    localparam int NSETS    = 1 << SETS_LOG2;
    localparam logic [SETS_LOG2-1:0] LAST_SET = SETS_LOG2'(NSETS - 1);

    ctrl_state_e state_q, state_d;

    logic [SETS_LOG2-1:0] vidx_q;
    logic [TAG_W-1:0]     ppn_q;
    logic [1:0]           code_q;
    logic                 flush_pend_q;
    logic [SETS_LOG2-1:0] fcnt_q;

    logic [SETS_LOG2-1:0] pidx, src_idx;
    logic                 accept;
    logic                 rd_valid, vic_valid;
    logic [TAG_W-1:0]     rd_tag, vic_tag;
    logic                 lk_hit, lk_fetch;
    logic                 wr_en, inv_en;
    logic [SETS_LOG2-1:0] wr_idx, inv_idx;
    logic                 unused_ofs;

    assign unused_ofs = ^cpu_req_vaddr[LINE_W-1:0];

    // correct set: translated speculative bits over untranslated in-page bits
    assign pidx    = {ppn_q[NSPEC-1:0], vidx_q[INPAGE_W-1:0]};
    assign src_idx = {~pidx[SETS_LOG2-1], pidx[SETS_LOG2-2:0]};

    vipt_tag_store #(
        .SETS_LOG2 (SETS_LOG2),
        .TAG_W     (TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (vidx_q),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .vic_idx   (pidx),
        .vic_valid (vic_valid),
        .vic_tag   (vic_tag),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (ppn_q),
        .inv_en    (inv_en),
        .inv_idx   (inv_idx)
    );

    vipt_tag_cmp #(
        .TAG_W (TAG_W)
    ) u_cmp (
        .ent_valid  (rd_valid),
        .ent_tag    (rd_tag),
        .xl_tag     (xlat_rsp_ppn),
        .xl_fault   (xlat_rsp_fault),
        .hit        (lk_hit),
        .need_fetch (lk_fetch)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush || flush_pend_q) state_d = ST_FLUSH;
                else if (cpu_req_valid)    state_d = ST_XLAT;
            end
            ST_XLAT: begin
                if (xlat_rsp_valid) state_d = lk_fetch ? ST_MISS_REQ : ST_RESP;
            end
            ST_MISS_REQ: begin
                if (nl_req_ready) state_d = ST_MISS_WAIT;
            end
            ST_MISS_WAIT: begin
                if (nl_rsp_valid) state_d = nl_rsp_alias ? ST_MOVE_REQ : ST_RESP;
            end
            ST_MOVE_REQ: begin
                if (nl_req_ready) state_d = ST_MOVE_WAIT;
            end
            ST_MOVE_WAIT: begin
                if (nl_rsp_valid) state_d = ST_RESP;
            end
            ST_RESP: begin
                if (cpu_rsp_ready) state_d = ST_IDLE;
            end
            ST_FLUSH: begin
                if (fcnt_q == LAST_SET) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            vidx_q       <= '0;
            ppn_q        <= '0;
            code_q       <= RSP_HIT;
            flush_pend_q <= 1'b0;
            fcnt_q       <= '0;
        end else begin
            state_q      <= state_d;
            flush_pend_q <= (flush_pend_q || flush) &&
                            !(state_q == ST_IDLE && state_d == ST_FLUSH);
            if (state_q == ST_FLUSH) fcnt_q <= fcnt_q + 1'b1;
            else                     fcnt_q <= '0;
            if (accept) vidx_q <= cpu_req_vaddr[PAGE_W+NSPEC-1:LINE_W];
            if (state_q == ST_XLAT && xlat_rsp_valid) begin
                ppn_q <= xlat_rsp_ppn;
                if (xlat_rsp_fault) code_q <= RSP_FAULT;
                else if (lk_hit)    code_q <= RSP_HIT;
            end
            if (state_q == ST_MISS_WAIT && nl_rsp_valid && !nl_rsp_alias) code_q <= RSP_FILL;
            if (state_q == ST_MOVE_WAIT && nl_rsp_valid)                  code_q <= RSP_MOVED;
        end
    end

    // outputs and array controls
    always_comb begin
        cpu_req_ready       = (state_q == ST_IDLE) && !flush && !flush_pend_q;
        accept              = cpu_req_ready && cpu_req_valid;
        xlat_req_valid      = accept;
        xlat_req_vpn        = cpu_req_vaddr[ADDR_W-1:PAGE_W];
        cpu_rsp_valid       = (state_q == ST_RESP);
        cpu_rsp_code        = code_q;
        nl_req_valid        = (state_q == ST_MISS_REQ) || (state_q == ST_MOVE_REQ);
        nl_req_op           = (state_q == ST_MOVE_REQ) ? NL_MOVE : NL_FETCH;
        nl_req_paddr        = {ppn_q, vidx_q[INPAGE_W-1:0], {LINE_W{1'b0}}};
        nl_req_victim_valid = vic_valid;
        nl_req_victim_tag   = vic_tag;
        nl_rsp_ready        = (state_q == ST_MISS_WAIT) || (state_q == ST_MOVE_WAIT);
        wr_en               = nl_rsp_valid &&
                              ((state_q == ST_MISS_WAIT && !nl_rsp_alias) ||
                               (state_q == ST_MOVE_WAIT));
        wr_idx              = (state_q == ST_MISS_WAIT) ? vidx_q : pidx;
        inv_en              = (state_q == ST_FLUSH) ||
                              (state_q == ST_MOVE_WAIT && nl_rsp_valid);
        inv_idx             = (state_q == ST_FLUSH) ? fcnt_q : src_idx;
    end

    // R2
    idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_ready |-> (!cpu_rsp_valid && !nl_req_valid && !nl_rsp_ready));

    // R4
    nl_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nl_req_valid && !nl_req_ready)
            |=> (nl_req_valid && $stable(nl_req_paddr) && $stable(nl_req_op)));

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_code)));

    // R7
    fault_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XLAT && xlat_rsp_valid && xlat_rsp_fault)
            |=> (cpu_rsp_valid && cpu_rsp_code == RSP_FAULT && !nl_req_valid));

endmodule

// File: tb/vipt_l1_ctrl_tb.sv
module vipt_l1_ctrl_tb;

    localparam logic [1:0] C_HIT = 2'd0, C_FILL = 2'd1, C_MOVED = 2'd2, C_FAULT = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic [31:0] cpu_req_vaddr = '0;
    logic        cpu_rsp_valid;
    logic        cpu_rsp_ready = 1'b0;
    logic [1:0]  cpu_rsp_code;
    logic        xlat_req_valid;
    logic [19:0] xlat_req_vpn;
    logic        xlat_rsp_valid = 1'b0;
    logic [19:0] xlat_rsp_ppn = '0;
    logic        xlat_rsp_fault = 1'b0;
    logic        nl_req_valid;
    logic        nl_req_ready = 1'b0;
    logic        nl_req_op;
    logic [31:0] nl_req_paddr;
    logic        nl_req_victim_valid;
    logic [19:0] nl_req_victim_tag;
    logic        nl_rsp_valid = 1'b0;
    logic        nl_rsp_ready;
    logic        nl_rsp_alias = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bit          ref_v [128];
    logic [19:0] ref_t [128];

    always #4 clk = ~clk;

    vipt_l1_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .flush (flush),
        .cpu_req_valid (cpu_req_valid), .cpu_req_ready (cpu_req_ready),
        .cpu_req_vaddr (cpu_req_vaddr),
        .cpu_rsp_valid (cpu_rsp_valid), .cpu_rsp_ready (cpu_rsp_ready),
        .cpu_rsp_code (cpu_rsp_code),
        .xlat_req_valid (xlat_req_valid), .xlat_req_vpn (xlat_req_vpn),
        .xlat_rsp_valid (xlat_rsp_valid), .xlat_rsp_ppn (xlat_rsp_ppn),
        .xlat_rsp_fault (xlat_rsp_fault),
        .nl_req_valid (nl_req_valid), .nl_req_ready (nl_req_ready),
        .nl_req_op (nl_req_op), .nl_req_paddr (nl_req_paddr),
        .nl_req_victim_valid (nl_req_victim_valid),
        .nl_req_victim_tag (nl_req_victim_tag),
        .nl_rsp_valid (nl_rsp_valid), .nl_rsp_ready (nl_rsp_ready),
        .nl_rsp_alias (nl_rsp_alias)
    );

    // translation stub mapping: pages 0 and 5 are synonyms with different bit 12
    function automatic logic [19:0] map_ppn(input logic [19:0] vpn);
        return 20'h40000 | {18'h0, vpn[1:0] ^ {1'b0, vpn[2]}};
    endfunction

    function automatic bit map_fault(input logic [19:0] vpn);
        return vpn == 20'd6;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int i = 0; i < 128; i++) ref_v[i] = 1'b0;
    endtask

    task automatic do_access(input logic [19:0] vpn, input int low, input int off,
                             input bit mid_flush, output logic [1:0] code);
        logic [31:0] va;
        logic [19:0] ppn;
        bit          flt;
        int          vidx, pidx, src;
        va   = {vpn, 6'(low), 6'(off)};
        ppn  = map_ppn(vpn);
        flt  = map_fault(vpn);
        vidx = {vpn[0], 6'(low)};
        pidx = {ppn[0], 6'(low)};
        src  = pidx ^ 64;
        if (flt)                                   code = C_FAULT;
        else if (ref_v[vidx] && ref_t[vidx] == ppn) code = C_HIT;
        else if (ref_v[src] && ref_t[src] == ppn)   code = C_MOVED;
        else                                       code = C_FILL;

        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_vaddr = va;
        #1;
        chk(cpu_req_ready, "R2 ready in idle", 32'(cpu_req_ready), 1);
        chk(xlat_req_valid && xlat_req_vpn == vpn, "R2 translation start",
            32'(xlat_req_vpn), 32'(vpn));
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (mid_flush) flush = 1'b1;
        #1;
        chk(!cpu_req_ready, "R2 busy after accept", 32'(cpu_req_ready), 0);
        @(negedge clk);
        flush          = 1'b0;
        xlat_rsp_valid = 1'b1;
        xlat_rsp_ppn   = ppn;
        xlat_rsp_fault = flt;
        @(negedge clk);
        xlat_rsp_valid = 1'b0;
        xlat_rsp_fault = 1'b0;
        #1;
        if (code == C_HIT || code == C_FAULT) begin
            chk(!nl_req_valid, "R3/R7 no next-level request", 32'(nl_req_valid), 0);
        end else begin
            chk(nl_req_valid && nl_req_op == 1'b0, "R4 fetch request",
                32'(nl_req_op), 0);
            chk(nl_req_paddr == {ppn, 6'(low), 6'd0}, "R4 line address",
                nl_req_paddr, {ppn, 6'(low), 6'd0});
            @(negedge clk);
            #1;
            chk(nl_req_valid && nl_req_paddr == {ppn, 6'(low), 6'd0},
                "R4 request held while stalled", nl_req_paddr, {ppn, 6'(low), 6'd0});
            nl_req_ready = 1'b1;
            @(negedge clk);
            nl_req_ready = 1'b0;
            nl_rsp_valid = 1'b1;
            nl_rsp_alias = (code == C_MOVED);
            #1;
            chk(nl_rsp_ready, "R4 response accepted", 32'(nl_rsp_ready), 1);
            @(negedge clk);
            nl_rsp_valid = 1'b0;
            nl_rsp_alias = 1'b0;
            #1;
            if (code == C_MOVED) begin
                chk(nl_req_valid && nl_req_op == 1'b1, "R6 move request",
                    32'(nl_req_op), 1);
                chk(nl_req_paddr == {ppn, 6'(low), 6'd0}, "R6 move address",
                    nl_req_paddr, {ppn, 6'(low), 6'd0});
                chk(nl_req_victim_valid == ref_v[pidx], "R6 victim valid",
                    32'(nl_req_victim_valid), 32'(ref_v[pidx]));
                if (ref_v[pidx])
                    chk(nl_req_victim_tag == ref_t[pidx], "R6 victim tag",
                        32'(nl_req_victim_tag), 32'(ref_t[pidx]));
                nl_req_ready = 1'b1;
                @(negedge clk);
                nl_req_ready = 1'b0;
                nl_rsp_valid = 1'b1;
                @(negedge clk);
                nl_rsp_valid = 1'b0;
                #1;
            end
        end
        chk(cpu_rsp_valid && cpu_rsp_code == code, "R3/R5/R6/R7 answer code",
            32'(cpu_rsp_code), 32'(code));
        @(negedge clk);
        #1;
        chk(cpu_rsp_valid && cpu_rsp_code == code, "R8 answer held",
            32'(cpu_rsp_code), 32'(code));
        cpu_rsp_ready = 1'b1;
        @(negedge clk);
        cpu_rsp_ready = 1'b0;
        #1;
        if (code == C_FILL) begin
            ref_v[vidx] = 1'b1;
            ref_t[vidx] = ppn;
        end else if (code == C_MOVED) begin
            ref_v[pidx] = 1'b1;
            ref_t[pidx] = ppn;
            ref_v[src]  = 1'b0;
        end
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (!cpu_req_ready && n < 1000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            finish_run();
        end
    end

    initial begin : main
        logic [1:0] c;
        int n;
        void'($urandom(32'h5EED_0042));
        model_flush();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1
        chk(cpu_req_ready, "R1 ready after reset", 32'(cpu_req_ready), 1);
        chk(!cpu_rsp_valid && !nl_req_valid, "R1 quiet after reset",
            32'({cpu_rsp_valid, nl_req_valid}), 0);

        do_access(20'd5, 2, 8, 1'b0, c);
        chk(c == C_FILL, "R1 first access fills", 32'(c), 32'(C_FILL));
        do_access(20'd5, 2, 40, 1'b0, c);
        chk(c == C_HIT, "R3 same line hits", 32'(c), 32'(C_HIT));
        do_access(20'd0, 2, 0, 1'b0, c);
        chk(c == C_MOVED, "R6 synonym relocated", 32'(c), 32'(C_MOVED));
        do_access(20'd0, 2, 4, 1'b0, c);
        chk(c == C_HIT, "R6 relocated line hits", 32'(c), 32'(C_HIT));
        do_access(20'd6, 2, 0, 1'b0, c);
        chk(c == C_FAULT, "R7 fault answer", 32'(c), 32'(C_FAULT));
        do_access(20'd0, 2, 12, 1'b0, c);
        chk(c == C_HIT, "R7 state unchanged by fault", 32'(c), 32'(C_HIT));
        do_access(20'd5, 2, 0, 1'b0, c);
        chk(c == C_FILL, "R6 source set emptied", 32'(c), 32'(C_FILL));

        do_access(20'd1, 3, 0, 1'b1, c);
        count_stall(n);
        chk(n == 129, "R10 deferred flush stall", 32'(n), 129);
        model_flush();
        do_access(20'd0, 2, 0, 1'b0, c);
        chk(c == C_FILL, "R9 entries invalid after flush", 32'(c), 32'(C_FILL));

        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        #1;
        count_stall(n);
        chk(n == 128, "R9 flush stall length", 32'(n), 128);
        model_flush();
        do_access(20'd0, 2, 0, 1'b0, c);
        chk(c == C_FILL, "R9 line gone after flush", 32'(c), 32'(C_FILL));

        for (int i = 0; i < 300; i++) begin
            do_access(20'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 63)), 1'b0, c);
        end

        finished = 1'b1;
        finish_run();
    end

endmodule